// File: doc/BRIEF.md
# PCI Configuration Access Engine

This block takes one configuration-space request from a processor-side port and carries it out as one or two 32-bit transfers on a simple request/acknowledge downstream port. A request names a bus, slot, function, register offset, an access size of one, two or four bytes, a direction and write data. The engine forms the configuration address from these fields. For bus 0 it uses a one-hot device select, and for any other bus it uses a bus/slot field with a type-1 flag. It then splits that address between an offset inside a fixed, power-of-two address window and a translation offset that the downstream side applies above the window.

Reads always move a full dword, and the engine returns the selected lanes right-justified. A byte or halfword write reads the containing dword, replaces the addressed lane and writes the dword back. A dword write is a single transfer. Requests that cannot be encoded are refused with an error status and never reach the downstream port. This covers misaligned sizes and addresses that fall beyond the window without being a multiple of it. Between requests, the translation offset and type-1 flag sit at their resting values. The engine saves them when it accepts a request and puts them back once the request has finished.

Top module: `cfg_access_engine`

## Requirements
- R1: With bus number 0 the cycle is type 0: the configuration address is 0x800 shifted left by the 5-bit slot number, truncated to 32 bits, so slot 0 selects address bit 11 and slots 21 to 31 give an address of zero. The type-1 flag is low.
- R2: With a nonzero bus number the configuration address holds the 8-bit bus in bits 23:16 and the slot in bits 15:11, and the type-1 flag is high for the whole transfer.
- R3: The downstream address is WIN_BASE, plus the in-window part of the configuration address, plus the function number times 256, plus the register offset with its two low bits cleared.
- R4: A configuration address below 2^WIN_LOG2 is placed in the window and the translation offset is zero. Otherwise the in-window part is zero and the translation offset carries the whole configuration address. When such an address is not a multiple of 2^WIN_LOG2, the request completes with an error and no transfer. WIN_LOG2 is at least 21.
- R5: Size code 0 is byte, 1 is halfword and 2 is dword. A read returns the dword shifted right by 8 times offset[1:0] for a byte, or by 16 times offset[1] for a halfword, then masked to the access width.
- R6: A byte or halfword write issues exactly two transfers: a read, then a write of the dword read with the target lane replaced by the new data at the same shift as R5.
- R7: A dword write issues exactly one write transfer carrying the request data unchanged.
- R8: Size code 3, a halfword with offset bit 0 set, or a dword with offset bits 1:0 nonzero completes with the error flag set and no downstream transfer.
- R9: busy is high from the cycle after acceptance until the final acknowledge. The completion pulse coincides with busy falling, and requests presented while busy are ignored.
- R10: An error on the read phase of a read-modify-write ends the request with the error flag and no write transfer. An error on any single transfer is returned in the error flag.
- R11: Whenever no transfer is pending, the translation offset equals XLATE_REST and the type-1 flag is low, and these values are restored after every request.
- R12: While a transfer waits for its acknowledge, its address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Bus number |
| req_slot | input | 5 | Slot number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 dword, 3 invalid |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Request in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error status of the completed request |
| rsp_rdata | output | 32 | Right-justified read result |
| dn_req | output | 1 | Downstream transfer request |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | 32 | Downstream address inside the window |
| dn_xlate | output | 32 | Translation offset |
| dn_type1 | output | 1 | Type-1 cycle flag |
| dn_wdata | output | 32 | Downstream write dword |
| dn_ack | input | 1 | Transfer acknowledge |
| dn_rdata | input | 32 | Read dword, valid with acknowledge |
| dn_err | input | 1 | Transfer error, valid with acknowledge |

## Verification
Two things happen on the same clock edge: the final acknowledge of one request and the arrival of another request. On that edge the engine retires the first request and must still count as busy. The bench provokes this by holding a different request on the input from the cycle after acceptance through the edge that ends the transfer. It then judges that the downstream port saw only the first request's transfers and that no extra transfer appears afterwards. The read acknowledge and the launch of the merged write also share an edge. The bench catches a bad handover there by comparing the written dword with a merge it computes itself.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int DW     = 32;
    localparam int BUS_W  = 8;
    localparam int SLOT_W = 5;
    localparam int FUNC_W = 3;
    localparam int OFF_W  = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } cfg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_e;

    typedef struct packed {
        eng_state_e     state;
        logic           dn_req;
        logic           dn_write;
        logic [DW-1:0]  dn_addr;
        logic [DW-1:0]  dn_xlate;
        logic           dn_type1;
        logic [DW-1:0]  dn_wdata;
        logic [DW-1:0]  xlate_sav;
        logic           type1_sav;
        cfg_size_e      size;
        logic [1:0]     lane;
        logic           is_write;
        logic [DW-1:0]  wdata;
        logic           done;
        logic           err;
        logic [DW-1:0]  rdata;
    } eng_regs_t;

endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
    import cfg_pkg::*;
#(
    parameter logic [DW-1:0] WIN_BASE = 32'h1400_0000,
    parameter int            WIN_LOG2 = 21
) (
    input  logic [BUS_W-1:0]  bus_num,
    input  logic [SLOT_W-1:0] slot_num,
    input  logic [FUNC_W-1:0] func_num,
    input  logic [OFF_W-1:0]  reg_off,
    input  cfg_size_e         size,
    output logic [DW-1:0]     acc_addr,
    output logic [DW-1:0]     xlate,
    output logic              type1,
    output logic              unreachable,
    output logic              misaligned
);

    localparam logic [DW-1:0] WIN_MASK = (DW'(1) << WIN_LOG2) - DW'(1);

    logic [DW-1:0] cfg_addr;
    logic          in_win;

    always_comb begin
        type1 = |bus_num;
        if (type1) begin
            cfg_addr = (DW'(bus_num) << 16) | (DW'(slot_num) << 11);
        end else begin
            cfg_addr = DW'(32'h800) << slot_num;
        end
        in_win      = (cfg_addr & ~WIN_MASK) == '0;
        unreachable = !in_win && ((cfg_addr & WIN_MASK) != '0);
        xlate       = in_win ? '0 : cfg_addr;
        acc_addr    = WIN_BASE
                    + (in_win ? cfg_addr : '0)
                    + (DW'(func_num) << 8)
                    + (DW'(reg_off) & DW'(32'h0000_00FC));
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = reg_off[0];
            SZ_WORD: misaligned = |reg_off[1:0];
            default: misaligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
    import cfg_pkg::*;
(
    input  logic [DW-1:0] dword,
    input  cfg_size_e     size,
    input  logic [1:0]    lane,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_just,
    output logic [DW-1:0] merged
);

    logic [4:0]    shift;
    logic [DW-1:0] mask;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                mask  = DW'(32'h0000_00FF);
                shift = {lane, 3'b000};
            end
            SZ_HALF: begin
                mask  = DW'(32'h0000_FFFF);
                shift = {lane[1], 4'b0000};
            end
            default: begin
                mask  = '1;
                shift = 5'd0;
            end
        endcase
        rd_just = (dword >> shift) & mask;
        merged  = (dword & ~(mask << shift)) | ((wdata & mask) << shift);
    end

endmodule

// File: rtl/cfg_access_engine.sv
module cfg_access_engine
    import cfg_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'h1400_0000,
    parameter int          WIN_LOG2   = 21,
    parameter logic [31:0] XLATE_REST = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_slot,
    input  logic [2:0]  req_func,
    input  logic [7:0]  req_off,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        rsp_done,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        dn_req,
    output logic        dn_write,
    output logic [31:0] dn_addr,
    output logic [31:0] dn_xlate,
    output logic        dn_type1,
    output logic [31:0] dn_wdata,
    input  logic        dn_ack,
    input  logic [31:0] dn_rdata,
    input  logic        dn_err
);

    if (WIN_LOG2 < 21 || WIN_LOG2 > 31) begin : g_win_check
        $error("WIN_LOG2 must lie in 21..31");
    end

    localparam eng_regs_t RESET_REGS = '{
        state:     ST_IDLE,
        dn_req:    1'b0,
        dn_write:  1'b0,
        dn_addr:   '0,
        dn_xlate:  XLATE_REST,
        dn_type1:  1'b0,
        dn_wdata:  '0,
        xlate_sav: XLATE_REST,
        type1_sav: 1'b0,
        size:      SZ_BYTE,
        lane:      2'b00,
        is_write:  1'b0,
        wdata:     '0,
        done:      1'b0,
        err:       1'b0,
        rdata:     '0
    };

    eng_regs_t regs_d, regs_q;

    cfg_size_e     req_size_e;
    logic [DW-1:0] gen_addr;
    logic [DW-1:0] gen_xlate;
    logic          gen_type1;
    logic          gen_unreach;
    logic          gen_misalign;
    logic [DW-1:0] lane_rd;
    logic [DW-1:0] lane_merged;

    assign req_size_e = cfg_size_e'(req_size);

    cfg_addr_gen #(
        .WIN_BASE (WIN_BASE),
        .WIN_LOG2 (WIN_LOG2)
    ) addr_gen_i (
        .bus_num     (req_bus),
        .slot_num    (req_slot),
        .func_num    (req_func),
        .reg_off     (req_off),
        .size        (req_size_e),
        .acc_addr    (gen_addr),
        .xlate       (gen_xlate),
        .type1       (gen_type1),
        .unreachable (gen_unreach),
        .misaligned  (gen_misalign)
    );

    cfg_lane_unit lane_unit_i (
        .dword   (dn_rdata),
        .size    (regs_q.size),
        .lane    (regs_q.lane),
        .wdata   (regs_q.wdata),
        .rd_just (lane_rd),
        .merged  (lane_merged)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (gen_misalign || gen_unreach) begin
                        regs_d.done = 1'b1;
                        regs_d.err  = 1'b1;
                    end else begin
                        regs_d.xlate_sav = regs_q.dn_xlate;
                        regs_d.type1_sav = regs_q.dn_type1;
                        regs_d.dn_req    = 1'b1;
                        regs_d.dn_addr   = gen_addr;
                        regs_d.dn_xlate  = gen_xlate;
                        regs_d.dn_type1  = gen_type1;
                        regs_d.size      = req_size_e;
                        regs_d.lane      = req_off[1:0];
                        regs_d.is_write  = req_write;
                        regs_d.wdata     = req_wdata;
                        regs_d.err       = 1'b0;
                        if (req_write && req_size_e == SZ_WORD) begin
                            regs_d.dn_write = 1'b1;
                            regs_d.dn_wdata = req_wdata;
                            regs_d.state    = ST_WRITE;
                        end else begin
                            regs_d.dn_write = 1'b0;
                            regs_d.state    = ST_READ;
                        end
                    end
                end
            end
            ST_READ: begin
                if (dn_ack) begin
                    if (!dn_err && regs_q.is_write) begin
                        regs_d.dn_write = 1'b1;
                        regs_d.dn_wdata = lane_merged;
                        regs_d.state    = ST_WRITE;
                    end else begin
                        if (!dn_err) begin
                            regs_d.rdata = lane_rd;
                        end
                        regs_d.err      = dn_err;
                        regs_d.done     = 1'b1;
                        regs_d.state    = ST_IDLE;
                        regs_d.dn_req   = 1'b0;
                        regs_d.dn_write = 1'b0;
                        regs_d.dn_xlate = regs_q.xlate_sav;
                        regs_d.dn_type1 = regs_q.type1_sav;
                    end
                end
            end
            ST_WRITE: begin
                if (dn_ack) begin
                    regs_d.err      = dn_err;
                    regs_d.done     = 1'b1;
                    regs_d.state    = ST_IDLE;
                    regs_d.dn_req   = 1'b0;
                    regs_d.dn_write = 1'b0;
                    regs_d.dn_xlate = regs_q.xlate_sav;
                    regs_d.dn_type1 = regs_q.type1_sav;
                end
            end
            default: begin
                regs_d = RESET_REGS;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RESET_REGS;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign busy      = regs_q.state != ST_IDLE;
    assign rsp_done  = regs_q.done;
    assign rsp_err   = regs_q.err;
    assign rsp_rdata = regs_q.rdata;
    assign dn_req    = regs_q.dn_req;
    assign dn_write  = regs_q.dn_write;
    assign dn_addr   = regs_q.dn_addr;
    assign dn_xlate  = regs_q.dn_xlate;
    assign dn_type1  = regs_q.dn_type1;
    assign dn_wdata  = regs_q.dn_wdata;

endmodule

// File: rtl/cfg_access_engine_chk.sv
module cfg_access_engine_chk #(
    parameter logic [31:0] WIN_BASE   = 32'h1400_0000,
    parameter int          WIN_LOG2   = 21,
    parameter logic [31:0] XLATE_REST = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        rsp_done,
    input logic        dn_req,
    input logic        dn_write,
    input logic [31:0] dn_addr,
    input logic [31:0] dn_xlate,
    input logic        dn_type1,
    input logic [31:0] dn_wdata,
    input logic        dn_ack,
    input logic        dn_err
);

    p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_write)
                              && $stable(dn_wdata) && $stable(dn_xlate));

    p_rest_values_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_req |-> dn_xlate == XLATE_REST && !dn_type1);

    p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> busy);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !busy && !dn_req);

    p_write_follows_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_write && $past(dn_req) && !$past(dn_write) |-> $past(dn_ack));

    p_read_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_write && dn_ack && dn_err |=> !dn_req);

    p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> (dn_addr - WIN_BASE) < (32'd1 << WIN_LOG2));

endmodule

bind cfg_access_engine cfg_access_engine_chk #(
    .WIN_BASE   (WIN_BASE),
    .WIN_LOG2   (WIN_LOG2),
    .XLATE_REST (XLATE_REST)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rsp_done (rsp_done),
    .dn_req   (dn_req),
    .dn_write (dn_write),
    .dn_addr  (dn_addr),
    .dn_xlate (dn_xlate),
    .dn_type1 (dn_type1),
    .dn_wdata (dn_wdata),
    .dn_ack   (dn_ack),
    .dn_err   (dn_err)
);

// File: tb/cfg_access_engine_tb_top.sv
`timescale 1ns/1ps
module cfg_access_engine_tb_top;

    localparam logic [31:0] BASE = 32'h1400_0000;
    localparam int          WL2  = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_slot = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_done, rsp_err;
    logic [31:0] rsp_rdata;
    logic        dn_req, dn_write, dn_type1;
    logic [31:0] dn_addr, dn_xlate, dn_wdata;
    logic        dn_ack = 1'b0;
    logic [31:0] dn_rdata = '0;
    logic        dn_err = 1'b0;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    bit  err_on_read = 1'b0;

    int          tr_total = 0;
    logic [31:0] tr_addr  [4];
    logic [31:0] tr_xlate [4];
    logic [31:0] tr_wdata [4];
    logic        tr_type1 [4];
    logic        tr_write [4];

    always #2.5 clk = ~clk;

    cfg_access_engine #(
        .WIN_BASE   (BASE),
        .WIN_LOG2   (WL2),
        .XLATE_REST (32'h0)
    ) dut_i (
        .clk, .rst_n, .req_valid, .req_write, .req_bus, .req_slot, .req_func,
        .req_off, .req_size, .req_wdata, .busy, .rsp_done, .rsp_err, .rsp_rdata,
        .dn_req, .dn_write, .dn_addr, .dn_xlate, .dn_type1, .dn_wdata,
        .dn_ack, .dn_rdata, .dn_err
    );

    function automatic logic [31:0] target_word(logic [31:0] a, logic [31:0] x);
        return (a ^ {x[15:0], x[31:16]}) * 32'h9E37_79B1 + 32'h1234_5678;
    endfunction

    // downstream target: acknowledge one cycle after each new request
    always @(negedge clk) begin
        if (dn_ack) begin
            dn_ack <= 1'b0;
            dn_err <= 1'b0;
        end else if (dn_req && rst_n) begin
            tr_addr[tr_total % 4]  <= dn_addr;
            tr_xlate[tr_total % 4] <= dn_xlate;
            tr_wdata[tr_total % 4] <= dn_wdata;
            tr_type1[tr_total % 4] <= dn_type1;
            tr_write[tr_total % 4] <= dn_write;
            tr_total <= tr_total + 1;
            dn_ack   <= 1'b1;
            dn_rdata <= target_word(dn_addr, dn_xlate);
            dn_err   <= !dn_write && err_on_read;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_access(input logic [7:0] b, input logic [4:0] s,
                              input logic [2:0] f, input logic [7:0] o,
                              input logic [1:0] sz, input bit wr,
                              input logic [31:0] wd, input bit rderr,
                              input bit junk);
        logic [31:0] cfg, exp_addr, exp_xlate, word, mask, exp_rd, exp_merge;
        logic [4:0]  sh;
        bit          inwin, reject;
        int          n_exp, base, waited;
        if (b == 0) cfg = 32'h800 << s;
        else        cfg = (32'(b) << 16) | (32'(s) << 11);
        inwin     = cfg < (32'd1 << WL2);
        exp_xlate = inwin ? 32'h0 : cfg;
        exp_addr  = BASE + (inwin ? cfg : 32'h0) + 32'(f) * 256 + 32'(o & 8'hFC);
        reject    = (!inwin && (cfg % (32'd1 << WL2)) != 0)
                 || sz == 2'd3 || (sz == 2'd1 && o[0]) || (sz == 2'd2 && o[1:0] != 0);
        case (sz)
            2'd0:    begin mask = 32'hFF;   sh = 5'(o[1:0] * 8); end
            2'd1:    begin mask = 32'hFFFF; sh = 5'(o[1] * 16); end
            default: begin mask = 32'hFFFF_FFFF; sh = 5'd0; end
        endcase
        word      = target_word(exp_addr, exp_xlate);
        exp_rd    = (word >> sh) & mask;
        exp_merge = (word & ~(mask << sh)) | ((wd & mask) << sh);
        if (reject)                  n_exp = 0;
        else if (!wr || sz == 2'd2)  n_exp = 1;
        else                         n_exp = rderr ? 1 : 2;

        base        = tr_total;
        err_on_read = rderr;
        req_valid = 1'b1; req_write = wr; req_bus = b; req_slot = s;
        req_func = f; req_off = o; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (n_exp > 0) check(busy == 1'b1, "R9 busy after accept", 32'(busy), 32'h1);
        if (junk) begin
            req_valid = 1'b1; req_write = 1'b1; req_bus = 8'h05; req_slot = 5'd3;
            req_size = 2'd2; req_off = 8'h10; req_wdata = 32'hDEAD_BEEF;
        end
        waited = 0;
        while (!rsp_done && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        check(rsp_done == 1'b1, "R9 completion", 32'(rsp_done), 32'h1);
        check(busy == 1'b0, "R9 idle at completion", 32'(busy), 32'h0);
        check(rsp_err == (reject || rderr && n_exp > 0 && !(wr && sz == 2'd2)),
              reject ? "R8/R4 refused" : "R10 error status",
              32'(rsp_err), 32'(reject || (rderr && !(wr && sz == 2'd2))));
        check(dn_xlate == 32'h0 && dn_type1 == 1'b0, "R11 resting values",
              dn_xlate, 32'h0);
        repeat (2) @(negedge clk);
        check(tr_total - base == n_exp, "R6/R7/R8 transfer count",
              32'(tr_total - base), 32'(n_exp));
        if (n_exp > 0 && tr_total - base == n_exp) begin
            check(tr_addr[base % 4] == exp_addr, "R3 address", tr_addr[base % 4], exp_addr);
            check(tr_xlate[base % 4] == exp_xlate, "R4 translation",
                  tr_xlate[base % 4], exp_xlate);
            check(tr_type1[base % 4] == (b != 0), b != 0 ? "R2 type1 flag" : "R1 type0 flag",
                  32'(tr_type1[base % 4]), 32'(b != 0));
            if (wr && sz == 2'd2) begin
                check(tr_write[base % 4] && tr_wdata[base % 4] == wd, "R7 dword write",
                      tr_wdata[base % 4], wd);
            end else begin
                check(tr_write[base % 4] == 1'b0, "R6 read first",
                      32'(tr_write[base % 4]), 32'h0);
            end
            if (!wr && !rderr) begin
                check(rsp_rdata == exp_rd, "R5 read lanes", rsp_rdata, exp_rd);
            end
            if (n_exp == 2) begin
                check(tr_write[(base + 1) % 4] && tr_addr[(base + 1) % 4] == exp_addr,
                      "R6 write back address", tr_addr[(base + 1) % 4], exp_addr);
                check(tr_wdata[(base + 1) % 4] == exp_merge, "R6 merged dword",
                      tr_wdata[(base + 1) % 4], exp_merge);
            end
        end
        err_on_read = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] buses [5] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !dn_req && !rsp_done, "R9 reset state", 32'(busy), 32'h0);
        check(dn_xlate == 32'h0 && !dn_type1, "R11 reset rest values", dn_xlate, 32'h0);

        // sweep: bus set x every slot x size x direction x low offset bits
        for (int bi = 0; bi < 5; bi++) begin
            for (int s = 0; s < 32; s++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        for (int lo = 0; lo < 4; lo++) begin
                            run_access(buses[bi], 5'(s), 3'((s + bi) % 8),
                                       8'(((s * 28) & 8'hFC) | lo), 2'(sz), wr[0],
                                       32'h0102_0304 * 32'(s + 1) ^ 32'(lo << 20),
                                       1'b0, 1'b0);
                        end
                    end
                end
            end
        end

        // R10: read-phase errors on byte/half writes and on plain reads
        run_access(8'd0, 5'd2, 3'd1, 8'h41, 2'd0, 1'b1, 32'hA5, 1'b1, 1'b0);
        run_access(8'd7, 5'd9, 3'd4, 8'h22, 2'd1, 1'b1, 32'hBEEF, 1'b1, 1'b0);
        run_access(8'd0, 5'd4, 3'd0, 8'h08, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0);

        // R9: a second request held across the final-acknowledge edge is ignored
        run_access(8'd0, 5'd6, 3'd2, 8'h13, 2'd0, 1'b1, 32'h77, 1'b0, 1'b1);
        run_access(8'd3, 5'd1, 3'd5, 8'h24, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule